// File: doc/BRIEF.md
# DRAM Controller and PHY Reset Release Sequencer

This block drives the reset lines of a DRAM controller and of its PHY and lets them go in a fixed, timed order. A start pulse asserts every line together: the two-line controller group, the two-line PHY group, and the separate analog and digital reset domains inside the PHY. The block then releases them one stage at a time. The PHY group goes first, then the controller group. After that the PHY analog domain is released, and the PHY digital domain goes last. A done flag marks the end of the sequence.

Each wait is a whole number of microseconds. A tick divider that counts `CLK_MHZ` clock cycles per microsecond measures them. The divider restarts at every stage change, so each stage lasts exactly its delay times `CLK_MHZ` cycles. The default waits are 1 µs and 5 µs at each level. The 5 µs wait between the analog and digital releases gives at least 1000 DRAM clocks when the DRAM clock is 200 MHz or faster. All outputs are active-low resets and come straight from flops. Control pins are plain levels and pulses; the block has no data stream.

Top module: `dram_rst_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises with no start, every reset output is 0 and `done` is 0.
- R2: A `start` sampled high while idle or finished asserts all six reset lines (value 0) and clears `done` in the cycle after that clock edge.
- R3: Both PHY group lines rise together exactly `PHY_HOLD_US*CLK_MHZ` cycles after the edge that accepted `start`.
- R4: Both controller group lines rise exactly `CTL_GAP_US*CLK_MHZ` cycles after the PHY group release, and never before it.
- R5: The PHY analog reset rises exactly `ANA_HOLD_US*CLK_MHZ` cycles after the controller group release.
- R6: The PHY digital reset rises exactly `DIG_GAP_US*CLK_MHZ` cycles after the analog release, and never before it. With the defaults this is 5 µs, or at least 1000 DRAM cycles at 200 MHz.
- R7: `done` rises on the same edge as the digital release. It stays high, with all lines released, until a new `start` is accepted.
- R8: A `start` that arrives while a sequence is running is ignored. This holds even when it lands on a stage-change edge: no stage is restarted or moved.
- R9: A `start` accepted after `done` re-asserts all lines and runs the full sequence again with the same timing.
- R10: The two lines of each group always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start | input | 1 | Pulse that begins a sequence when idle or finished |
| ctl_rst_n | output | CTL_LINES | Controller reset group, active low |
| phy_rst_n | output | PHY_LINES | PHY reset group, active low |
| phy_ana_rst_n | output | 1 | PHY analog domain reset, active low |
| phy_dig_rst_n | output | 1 | PHY digital domain reset, active low |
| done | output | 1 | High once the final release has happened |

## Verification
Two functions can fall in the same cycle here. One is a stage expiry. The other is the start decision: a restart or an ignored trigger. The bench provokes this by holding `start` high during exactly the last cycle of the first stage. The PHY release must still happen on that edge, and the controller release must come at the unchanged later cycle, which shows the trigger was neither taken nor let shift the timer. The second coincidence is the digital release and the rise of `done` on one edge. This is judged by sampling both one cycle before and on that edge.

// File: rtl/dram_rst_seq_pkg.sv
package dram_rst_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD_ALL,
    SQ_CTL_WAIT,
    SQ_ANA_WAIT,
    SQ_DIG_WAIT,
    SQ_DONE
  } seq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/drs_us_tick.sv
module drs_us_tick #(
  parameter int CLK_MHZ = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_MHZ - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr||tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3: the cycle counter never passes one microsecond
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/drs_us_timer.sv
module drs_us_timer #(
  parameter int US_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [US_W-1:0] target,
  output logic            expire
);
  localparam logic [US_W-1:0] ONE = US_W'(1);

  logic [US_W-1:0] us_q;

  assign expire = tick && (us_q == target - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     us_q <= '0;
    else if (clr)   us_q <= '0;
    else if (tick)  us_q <= us_q + ONE;
  end

  // R3: within a running stage the microsecond count stays below its target
  p_us_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (us_q < target));

endmodule

// File: rtl/drs_fsm.sv
module drs_fsm
  import dram_rst_seq_pkg::*;
#(
  parameter int US_W        = 3,
  parameter int PHY_HOLD_US = 1,
  parameter int CTL_GAP_US  = 5,
  parameter int ANA_HOLD_US = 1,
  parameter int DIG_GAP_US  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            expire,
  output logic            tmr_clr,
  output logic [US_W-1:0] target,
  output logic            phy_rel,
  output logic            ctl_rel,
  output logic            ana_rel,
  output logic            dig_rel,
  output logic            done
);
  seq_state_e state_q, state_d;
  logic       busy;

  assign busy    = (state_q != SQ_IDLE) && (state_q != SQ_DONE);
  assign tmr_clr = !busy || expire;

  always_comb begin
    case (state_q)
      SQ_CTL_WAIT: target = US_W'(CTL_GAP_US);
      SQ_ANA_WAIT: target = US_W'(ANA_HOLD_US);
      SQ_DIG_WAIT: target = US_W'(DIG_GAP_US);
      default:     target = US_W'(PHY_HOLD_US);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE, SQ_DONE: if (start)  state_d = SQ_HOLD_ALL;
      SQ_HOLD_ALL:      if (expire) state_d = SQ_CTL_WAIT;
      SQ_CTL_WAIT:      if (expire) state_d = SQ_ANA_WAIT;
      SQ_ANA_WAIT:      if (expire) state_d = SQ_DIG_WAIT;
      SQ_DIG_WAIT:      if (expire) state_d = SQ_DONE;
      default:                      state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      phy_rel <= 1'b0;
      ctl_rel <= 1'b0;
      ana_rel <= 1'b0;
      dig_rel <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      phy_rel <= state_d inside {SQ_CTL_WAIT, SQ_ANA_WAIT, SQ_DIG_WAIT, SQ_DONE};
      ctl_rel <= state_d inside {SQ_ANA_WAIT, SQ_DIG_WAIT, SQ_DONE};
      ana_rel <= state_d inside {SQ_DIG_WAIT, SQ_DONE};
      dig_rel <= (state_d == SQ_DONE);
      done    <= (state_d == SQ_DONE);
    end
  end

  // R8: a running stage only moves when the timer expires, whatever start does
  p_no_early_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> $stable(state_q));

  // R7: done holds while no new start arrives
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9: a start after completion drops done and every release
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DONE && start) |=> (!done && !phy_rel && !ctl_rel && !ana_rel && !dig_rel));

endmodule

// File: rtl/dram_rst_seq.sv
module dram_rst_seq
  import dram_rst_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int CTL_LINES   = 2,
  parameter int PHY_LINES   = 2,
  parameter int PHY_HOLD_US = 1,
  parameter int CTL_GAP_US  = 5,
  parameter int ANA_HOLD_US = 1,
  parameter int DIG_GAP_US  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic [CTL_LINES-1:0] ctl_rst_n,
  output logic [PHY_LINES-1:0] phy_rst_n,
  output logic                 phy_ana_rst_n,
  output logic                 phy_dig_rst_n,
  output logic                 done
);
  localparam int MAX_US  = max4(PHY_HOLD_US, CTL_GAP_US, ANA_HOLD_US, DIG_GAP_US);
  localparam int US_W    = $clog2(MAX_US + 1);
  localparam int GAP_CYC = DIG_GAP_US * CLK_MHZ;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  logic            tick, expire, tmr_clr;
  logic [US_W-1:0] target;
  logic            phy_rel, ctl_rel, ana_rel, dig_rel;

  drs_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
  );

  drs_us_timer #(.US_W(US_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
    .target(target), .expire(expire)
  );

  drs_fsm #(
    .US_W(US_W), .PHY_HOLD_US(PHY_HOLD_US), .CTL_GAP_US(CTL_GAP_US),
    .ANA_HOLD_US(ANA_HOLD_US), .DIG_GAP_US(DIG_GAP_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .expire(expire),
    .tmr_clr(tmr_clr), .target(target),
    .phy_rel(phy_rel), .ctl_rel(ctl_rel), .ana_rel(ana_rel),
    .dig_rel(dig_rel), .done(done)
  );

  for (genvar i = 0; i < CTL_LINES; i++) begin : g_ctl
    assign ctl_rst_n[i] = ctl_rel;
  end
  for (genvar j = 0; j < PHY_LINES; j++) begin : g_phy
    assign phy_rst_n[j] = phy_rel;
  end
  assign phy_ana_rst_n = ana_rel;
  assign phy_dig_rst_n = dig_rel;

  // Cycles spent with analog released and digital still held, saturating
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       gap_q <= '0;
    else if (!phy_ana_rst_n)                          gap_q <= '0;
    else if (!phy_dig_rst_n && gap_q != GAP_W'(GAP_CYC)) gap_q <= gap_q + 1'b1;
  end

  // R6: digital release only after the full analog-to-digital gap
  p_dig_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_dig_rst_n) |-> (gap_q >= GAP_W'(GAP_CYC)));

  // R4: controller group never leaves reset while the PHY group is held
  p_ctl_after_phy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rst_n[0]) |-> $past(phy_rst_n[0]));

endmodule

// File: tb/sim_dram_rst_seq.sv
`timescale 1ns/1ps
module sim_dram_rst_seq;
  localparam int N = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] ctl_rst_n, phy_rst_n;
  logic       phy_ana_rst_n, phy_dig_rst_n, done;

  int n_chk = 0;
  int n_bad = 0;
  int cur_k = 0;

  always #2.5 clk = ~clk;

  dram_rst_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctl_rst_n(ctl_rst_n), .phy_rst_n(phy_rst_n),
    .phy_ana_rst_n(phy_ana_rst_n), .phy_dig_rst_n(phy_dig_rst_n), .done(done)
  );

  // {done, dig, ana, phy[1:0], ctl[1:0]}
  function automatic logic [6:0] obs();
    return {done, phy_dig_rst_n, phy_ana_rst_n, phy_rst_n, ctl_rst_n};
  endfunction

  localparam int NV = 10;
  localparam int VK [NV] = '{0, N-1, N, 6*N-1, 6*N, 7*N-1, 7*N, 12*N-1, 12*N, 12*N+300};
  localparam logic [6:0] VE [NV] = '{7'h00, 7'h00, 7'h0C, 7'h0C, 7'h0F,
                                     7'h0F, 7'h1F, 7'h1F, 7'h7F, 7'h7F};

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (k=%0d)", tag, act, exp, cur_k);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cur_k = 0;
  endtask

  task automatic go_to(int k);
    while (cur_k < k) begin
      @(negedge clk);
      cur_k++;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1", obs(), 7'h00);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", obs(), 7'h00);

    // Table walk through one complete sequence (R2..R7)
    pulse_start();
    for (int i = 0; i < NV; i++) begin
      go_to(VK[i]);
      check(tag_of(i), obs(), VE[i]);
      check("R10", {^phy_rst_n, ^ctl_rst_n}, 2'b00);
    end

    // R7: done stays high long after completion
    go_to(12*N + 1500);
    check("R7", obs(), 7'h7F);

    // R9: restart from done
    pulse_start();
    check("R9", obs(), 7'h00);
    go_to(12*N - 1);
    check("R9", obs(), 7'h1F);
    go_to(12*N);
    check("R9", obs(), 7'h7F);

    // R8: start lands on the PHY release edge; it is ignored
    pulse_start();
    go_to(N-1);
    start = 1'b1;
    @(negedge clk); start = 1'b0; cur_k++;
    check("R8", obs(), 7'h0C);
    go_to(3*N);
    start = 1'b1;
    @(negedge clk); start = 1'b0; cur_k++;
    check("R8", obs(), 7'h0C);
    go_to(6*N-1);
    check("R8", obs(), 7'h0C);
    go_to(6*N);
    check("R8", obs(), 7'h0F);
    go_to(12*N);
    check("R8", obs(), 7'h7F);

    // R1: reset in mid-sequence returns everything to asserted
    pulse_start();
    go_to(6*N + 10);
    check("R4", obs(), 7'h0F);
    #1 rst_n = 1'b0;
    #1 check("R1", obs(), 7'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3*N) @(negedge clk);
    check("R1", obs(), 7'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule